// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block is a single-way lookup table that sits beside the fetch stage and answers one question each cycle: for the current program counter, is a taken-branch destination remembered, and if so, where does it point? The table has one slot per index value. Each slot holds a valid flag, a short partial tag and a full-width destination address. The index comes from the PC bits just above the instruction-offset field. The partial tag comes from the bits directly above the index.

A fetch unit drives the lookup port and reads back a hit flag and a predicted destination. The destination reads as zero whenever the flag is low. A second, lighter port reports only the hit condition for another PC. The branch resolution logic drives the update port with a resolved branch PC and its destination. The addressed slot is overwritten on the next clock edge whatever it held before. The tag is kept short on purpose, so two PCs that differ only above the tag field share a slot and may produce a false hit.

The block has no state machine. Every path is either combinational from the stored table or a single-edge write.

Top module: `btb_direct`

## Requirements
- R1: The slot index is `(pc >> OFS_SHIFT) & (ENTRIES-1)`. ENTRIES must be a power of two and at least 2, or elaboration stops with an error.
- R2: The partial tag is `(pc >> (OFS_SHIFT + log2(ENTRIES))) & (2**TAG_W - 1)`. TAG_W must lie between 1 and `PC_W - OFS_SHIFT - log2(ENTRIES)`, or elaboration stops with an error.
- R3: A synchronous, active-high `rst` clears every valid flag, so every lookup and query misses on the cycle after reset. Reset takes priority over an update in the same cycle.
- R4: `lk_hit` is 1 exactly when the indexed slot is valid and its stored tag equals the tag of `lk_pc`. On a hit, `lk_target` equals the stored destination.
- R5: When `lk_hit` is 0, `lk_target` is all zeros.
- R6: With `up_en` high at a rising edge, the slot indexed by `up_pc` becomes valid and takes `up_pc`'s tag and `up_target`. Whatever the slot held before is replaced.
- R7: `qv_hit` reports the same hit condition as R4, evaluated for `qv_pc`, without returning a destination.
- R8: Lookup and query are combinational from stored state. In the cycle an update is presented, a lookup of the same slot still returns the old contents.
- R9: Only the tag field is compared. PCs that differ only in bits above the tag field, or only in the offset bits, produce the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| lk_pc | input | PC_W | PC presented for lookup |
| lk_hit | output | 1 | Lookup found a matching valid slot |
| lk_target | output | PC_W | Predicted destination, zero on a miss |
| qv_pc | input | PC_W | PC presented for the hit-only query |
| qv_hit | output | 1 | Query found a matching valid slot |
| up_en | input | 1 | Write the slot addressed by `up_pc` at this edge |
| up_pc | input | PC_W | Resolved branch PC |
| up_target | input | PC_W | Resolved branch destination |

## Verification
Because reads are combinational, a corrupted valid flag, tag or destination shows up at `lk_hit`/`lk_target` in the very cycle the affected slot is addressed. A bad write therefore appears one edge after the update. A valid flag that survives reset appears as a spurious hit on the first cycle after reset. A wrong index or tag slice shows as hits on the wrong slot, as misses that never clear, or as aliasing in the wrong address bits. A sweep that covers every index, every tag value and both offset and high-bit variants exposes any of these.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Returns 1 when n is a power of two no smaller than two.
    function automatic bit is_pow2_ge2(int unsigned n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
// Derives slot index and partial tag from a program counter.
module btb_pc_split #(
    parameter int PC_W      = 32,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 8,
    parameter int OFS_SHIFT = 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam int TAG_LSB = OFS_SHIFT + IDX_W;

    assign idx = IDX_W'(pc >> OFS_SHIFT);
    assign tag = TAG_W'(pc >> TAG_LSB);
endmodule

// File: rtl/btb_table.sv
// Slot storage: valid flags with reset, tag and destination without.
module btb_table #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 8,
    parameter int TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output logic [TGT_W-1:0] ra_tgt,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && !rst) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_tgt;
            end
        end
    end

    assign ra_valid = valid_q[ra_idx];
    assign ra_tag   = tag_q[ra_idx];
    assign ra_tgt   = tgt_q[ra_idx];
    assign rb_valid = valid_q[rb_idx];
    assign rb_tag   = tag_q[rb_idx];
endmodule

// File: rtl/btb_match.sv
// Hit decision for one read port.
module btb_match #(
    parameter int TAG_W = 8
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             hit
);
    assign hit = slot_valid && (slot_tag == want_tag);
endmodule

// File: rtl/btb_direct.sv
module btb_direct
    import btb_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int ENTRIES   = 16,
    parameter int TAG_W     = 8,
    parameter int OFS_SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic [PC_W-1:0] qv_pc,
    output logic            qv_hit,
    input  logic            up_en,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target
);
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAG_LSB = OFS_SHIFT + IDX_W;

    // Configuration guard (R1, R2)
    if (!is_pow2_ge2(ENTRIES) || TAG_W < 1 || TAG_W > PC_W - TAG_LSB) begin : g_cfg_bad
        $error("btb_direct: illegal ENTRIES/TAG_W/OFS_SHIFT combination");
    end

    logic [IDX_W-1:0] lk_idx, qv_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, qv_tag, up_tag;
    logic             ra_valid, rb_valid;
    logic [TAG_W-1:0] ra_tag, rb_tag;
    logic [PC_W-1:0]  ra_tgt;

    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_SHIFT(OFS_SHIFT))
        u_split_lk (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_SHIFT(OFS_SHIFT))
        u_split_qv (.pc(qv_pc), .idx(qv_idx), .tag(qv_tag));
    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_SHIFT(OFS_SHIFT))
        u_split_up (.pc(up_pc), .idx(up_idx), .tag(up_tag));

    btb_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (up_en),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_tgt   (up_target),
        .ra_idx   (lk_idx),
        .ra_valid (ra_valid),
        .ra_tag   (ra_tag),
        .ra_tgt   (ra_tgt),
        .rb_idx   (qv_idx),
        .rb_valid (rb_valid),
        .rb_tag   (rb_tag)
    );

    btb_match #(.TAG_W(TAG_W)) u_match_lk (
        .slot_valid (ra_valid), .slot_tag (ra_tag), .want_tag (lk_tag), .hit (lk_hit)
    );
    btb_match #(.TAG_W(TAG_W)) u_match_qv (
        .slot_valid (rb_valid), .slot_tag (rb_tag), .want_tag (qv_tag), .hit (qv_hit)
    );

    assign lk_target = lk_hit ? ra_tgt : '0;
endmodule

// File: rtl/btb_direct_chk.sv
module btb_direct_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic [PC_W-1:0] lk_target,
    input logic [PC_W-1:0] qv_pc,
    input logic            qv_hit,
    input logic            up_en,
    input logic [PC_W-1:0] up_pc,
    input logic [PC_W-1:0] up_target
);
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_target == '0)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!lk_hit && !qv_hit)); // R3

    AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        up_en |=> ((lk_pc != $past(up_pc)) ||
                   (lk_hit && lk_target == $past(up_target)))); // R6

    AST_QUERY_AGREES: assert property (@(posedge clk) disable iff (rst)
        (qv_pc == lk_pc) |-> (qv_hit == lk_hit)); // R7
endmodule

bind btb_direct btb_direct_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_pc     (lk_pc),
    .lk_hit    (lk_hit),
    .lk_target (lk_target),
    .qv_pc     (qv_pc),
    .qv_hit    (qv_hit),
    .up_en     (up_en),
    .up_pc     (up_pc),
    .up_target (up_target)
);

// File: tb/tb_btb_direct.sv
`timescale 1ns/1ps
module tb_btb_direct;
    localparam int PW = 16;
    localparam int NE = 8;
    localparam int TW = 3;
    localparam int OS = 2;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] lk_pc = '0, qv_pc = '0, up_pc = '0, up_target = '0;
    logic [PW-1:0] lk_target;
    logic          lk_hit, qv_hit;
    logic          up_en = 1'b0;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    bit            mv  [NE];
    logic [TW-1:0] mtg [NE];
    logic [PW-1:0] mt  [NE];

    always #2 clk = ~clk;

    btb_direct #(.PC_W(PW), .ENTRIES(NE), .TAG_W(TW), .OFS_SHIFT(OS)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
        .qv_pc(qv_pc), .qv_hit(qv_hit), .up_en(up_en), .up_pc(up_pc), .up_target(up_target)
    );

    function automatic int idx_of(logic [PW-1:0] pc);
        return int'((pc >> OS) % NE);
    endfunction
    function automatic logic [TW-1:0] tag_of(logic [PW-1:0] pc);
        return TW'((pc >> (OS + IW)) % (1 << TW));
    endfunction

    task automatic check(string req, logic [PW-1:0] pc);
        int            i;
        bit            eh;
        logic [PW-1:0] et;
        lk_pc = pc;
        qv_pc = pc;
        #1;
        i  = idx_of(pc);
        eh = mv[i] && (mtg[i] == tag_of(pc));
        et = eh ? mt[i] : '0;
        n_run++;
        if (lk_hit !== eh || lk_target !== et || qv_hit !== eh) begin
            n_fail++;
            $display("FAIL %s pc=%h: hit=%b tgt=%h qv=%b expected hit=%b tgt=%h qv=%b",
                     req, pc, lk_hit, lk_target, qv_hit, eh, et, eh);
        end
    endtask

    task automatic do_update(logic [PW-1:0] pc, logic [PW-1:0] tgt);
        @(negedge clk);
        up_en = 1'b1;
        up_pc = pc;
        up_target = tgt;
        check("R8 old contents during update", pc);
        @(posedge clk);
        mv[idx_of(pc)]  = 1'b1;
        mtg[idx_of(pc)] = tag_of(pc);
        mt[idx_of(pc)]  = tgt;
        @(negedge clk);
        up_en = 1'b0;
        check("R6 written slot hits", pc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            mv[i] = 0; mtg[i] = '0; mt[i] = '0;
        end
        // R3: reset wins over a simultaneous update
        up_en = 1'b1;
        up_pc = 16'h0000;
        up_target = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        up_en = 1'b0;
        for (int i = 0; i < NE; i++) check("R3 reset clears valid", PW'(i << OS));

        // Fill every slot with its own tag and destination (R6, R8)
        for (int i = 0; i < NE; i++)
            do_update(PW'((((i ^ 5) % 8) << (OS + IW)) | (i << OS)), PW'(16'hA000 + i * 3 + 1));

        // Full sweep: index, tag, offset bits, high bits (R1 R2 R4 R5 R7 R9)
        @(negedge clk);
        for (int hi = 0; hi < 2; hi++)
            for (int t = 0; t < 8; t++)
                for (int i = 0; i < NE; i++)
                    for (int lo = 0; lo < 4; lo++)
                        check("R1/R2/R4/R5/R7/R9 sweep",
                              PW'(((hi * 8'h5A) << 8) | (t << 5) | (i << 2) | lo));

        // R6: overwrite slot 3 with another tag; the old tag must now miss
        do_update(PW'((3'd1 << 5) | (3 << 2)), 16'h7777);
        @(negedge clk);
        check("R6 old tag replaced", PW'((3'd6 << 5) | (3 << 2)));
        check("R6 new tag hits", PW'((3'd1 << 5) | (3 << 2) | 2));
        check("R9 high bits alias", PW'(16'hFF00 | (3'd1 << 5) | (3 << 2)));

        // R3: second reset clears a populated table
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NE; i++) mv[i] = 0;
        for (int i = 0; i < NE; i++)
            check("R3 reset after fill", PW'((((i ^ 5) % 8) << 5) | (i << 2)));

        finish_run();
    end
endmodule